// File: doc/BRIEF.md
# Transaction Burst Fragmenter

This block takes one transaction descriptor at a time: a source identifier, a destination identifier, a transaction identifier and a length in bytes. It cuts the transaction into burst fragments that a bus master can carry. The bus moves `BUS_BYTES` bytes per beat and a burst holds at most `MAX_BEATS` beats, so no fragment is larger than `BUS_BYTES * MAX_BEATS` bytes. Each fragment gives its byte count, the number of bus beats it needs and a flag that marks the final piece. The identifiers are repeated on every fragment. The data payload is not carried.

Both sides use a valid/ready handshake. While a transaction is being split, the input side stays closed, so a second descriptor cannot disturb the split in progress. A counter spaces handoffs on the output side at least `CYC_CLKS` clocks apart. With the default of 5 clocks at 50 MHz, that spacing equals one bus cycle of 100 ns. The spacing also holds between the last fragment of one transaction and the first fragment of the next.

Top module: `burst_fragmenter`

## Requirements
- R1: While reset is held, and after it is released with no descriptor offered, `in_ready` is 1 and `out_valid` is 0. `out_valid` is never 1 while `in_ready` is 1.
- R2: After a descriptor is accepted (`in_valid` and `in_ready` both high at a clock edge), `in_ready` stays 0 until the final fragment is handed off. Descriptors offered during that time are ignored and do not change any fragment.
- R3: Each fragment's `out_bytes` equals the smaller of the bytes still outstanding and `BUS_BYTES*MAX_BEATS`. The fragment byte counts of a transaction add up to its effective length, so the number of fragments is the effective length divided by `BUS_BYTES*MAX_BEATS`, rounded up.
- R4: `out_beats` equals `out_bytes` divided by `BUS_BYTES`, rounded up.
- R5: `out_last` is 1 only on the final fragment of a transaction. A transaction of exactly `BUS_BYTES*MAX_BEATS` bytes gives a single fragment with `out_last` set. `in_ready` returns to 1 in the cycle after that fragment is handed off.
- R6: `out_src`, `out_dst` and `out_tid` equal the `in_src`, `in_dst` and `in_tid` values captured at acceptance, on every fragment.
- R7: A length below 4 bytes, including 0, is treated as 4 bytes.
- R8: Two fragment handoffs (`out_valid` and `out_ready` both high at an edge) are at least `CYC_CLKS` clock edges apart. This holds across transaction boundaries.
- R9: Once `out_valid` is 1, it stays 1 with all fragment fields unchanged until `out_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Block can take a descriptor |
| in_src | input | SRC_W | Source identifier |
| in_dst | input | DST_W | Destination identifier |
| in_tid | input | TID_W | Transaction identifier |
| in_len | input | LEN_W | Transaction length in bytes |
| out_valid | output | 1 | Fragment offered |
| out_ready | input | 1 | Master takes the fragment |
| out_src | output | SRC_W | Source identifier of the fragment |
| out_dst | output | DST_W | Destination identifier of the fragment |
| out_tid | output | TID_W | Transaction identifier of the fragment |
| out_bytes | output | $clog2(BUS_BYTES*MAX_BEATS+1) | Bytes in this fragment |
| out_beats | output | $clog2(MAX_BEATS+1) | Bus beats for this fragment |
| out_last | output | 1 | Final fragment of the transaction |

## Verification
A corrupted remaining-byte register shows up on the next offered fragment: its byte count, its beat count or its last flag disagrees with the running total, and at the latest the byte sum of the transaction does not match. A stuck busy flag shows up one cycle after the final handoff, when `in_ready` fails to rise, or as a transaction that never finishes. A wrong spacing counter shows up at the first handoff that follows another one too soon.

// File: rtl/frag_pkg.sv
package frag_pkg;
  localparam int unsigned MIN_TXN_BYTES = 4;

  // integer division rounded up
  function automatic int unsigned div_up(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  // lengths below the legal minimum are raised to it
  function automatic int unsigned raise_len(input int unsigned len);
    return (len < MIN_TXN_BYTES) ? MIN_TXN_BYTES : len;
  endfunction

  // size of the next piece given outstanding bytes and the burst cap
  function automatic int unsigned piece_of(input int unsigned rem, input int unsigned cap);
    return (rem > cap) ? cap : rem;
  endfunction
endpackage

// File: rtl/frag_pace.sv
module frag_pace #(
  parameter int CYC_CLKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic go
);
  localparam int CNT_W = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
  localparam int SNC_W = $clog2(CYC_CLKS + 1) + 1;

  generate
    if (CYC_CLKS <= 1) begin : g_free
      assign go = 1'b1;
    end else begin : g_cnt
      logic [CNT_W-1:0] wait_q;
      always_ff @(posedge clk) begin
        if (!rst_n)            wait_q <= '0;
        else if (fire)         wait_q <= CNT_W'(CYC_CLKS - 1);
        else if (wait_q != '0) wait_q <= wait_q - 1'b1;
      end
      assign go = (wait_q == '0);
    end
  endgenerate

  // independent spacing monitor: clocks since the last handoff, saturating
  logic [SNC_W-1:0] since_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                      since_q <= SNC_W'(CYC_CLKS);
    else if (fire)                   since_q <= SNC_W'(1);
    else if (since_q < SNC_W'(CYC_CLKS)) since_q <= since_q + 1'b1;
  end

  p_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (since_q >= SNC_W'(CYC_CLKS)));
endmodule

// File: rtl/frag_split.sv
module frag_split #(
  parameter int LEN_W     = 16,
  parameter int BUS_BYTES = 8,
  parameter int MAX_BEATS = 16
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         load,
  input  logic [LEN_W-1:0]                             load_len,
  input  logic                                         take,
  output logic                                         busy,
  output logic [$clog2(BUS_BYTES*MAX_BEATS+1)-1:0]     piece_bytes,
  output logic [$clog2(MAX_BEATS+1)-1:0]               piece_beats,
  output logic                                         piece_last
);
  import frag_pkg::*;

  localparam int unsigned MAX_FRAG = BUS_BYTES * MAX_BEATS;
  localparam int FRAG_W = $clog2(MAX_FRAG + 1);
  localparam int BEAT_W = $clog2(MAX_BEATS + 1);

  logic [LEN_W-1:0] rem_q;
  logic             busy_q;
  logic [LEN_W-1:0] load_eff;
  int unsigned      rem_u;

  assign load_eff    = LEN_W'(raise_len(32'(load_len)));
  assign rem_u       = 32'(rem_q);
  assign piece_bytes = FRAG_W'(piece_of(rem_u, MAX_FRAG));
  assign piece_beats = BEAT_W'(div_up(32'(piece_bytes), BUS_BYTES));
  assign piece_last  = (rem_u <= MAX_FRAG);
  assign busy        = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      rem_q  <= load_eff;
    end else if (take) begin
      rem_q <= rem_q - LEN_W'(piece_bytes);
      if (piece_last) busy_q <= 1'b0;
    end
  end

  p_min_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (32'(load_len) < MIN_TXN_BYTES)) |=> (rem_q == LEN_W'(MIN_TXN_BYTES)));

  p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (piece_bytes != '0) && (32'(piece_bytes) <= MAX_FRAG));

  p_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !piece_last) |=> (rem_q < $past(rem_q)) && busy_q);
endmodule

// File: rtl/burst_fragmenter.sv
module burst_fragmenter #(
  parameter int BUS_BYTES = 8,
  parameter int MAX_BEATS = 16,
  parameter int LEN_W     = 16,
  parameter int SRC_W     = 4,
  parameter int DST_W     = 4,
  parameter int TID_W     = 8,
  parameter int CYC_CLKS  = 5
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      in_valid,
  output logic                                      in_ready,
  input  logic [SRC_W-1:0]                          in_src,
  input  logic [DST_W-1:0]                          in_dst,
  input  logic [TID_W-1:0]                          in_tid,
  input  logic [LEN_W-1:0]                          in_len,
  output logic                                      out_valid,
  input  logic                                      out_ready,
  output logic [SRC_W-1:0]                          out_src,
  output logic [DST_W-1:0]                          out_dst,
  output logic [TID_W-1:0]                          out_tid,
  output logic [$clog2(BUS_BYTES*MAX_BEATS+1)-1:0]  out_bytes,
  output logic [$clog2(MAX_BEATS+1)-1:0]            out_beats,
  output logic                                      out_last
);
  localparam int FRAG_W = $clog2(BUS_BYTES * MAX_BEATS + 1);
  localparam int BEAT_W = $clog2(MAX_BEATS + 1);

  // named internal events
  logic in_fire, out_fire, busy, pace_go;
  logic [FRAG_W-1:0] piece_bytes;
  logic [BEAT_W-1:0] piece_beats;
  logic              piece_last;

  logic [SRC_W-1:0] src_q;
  logic [DST_W-1:0] dst_q;
  logic [TID_W-1:0] tid_q;

  assign in_ready  = !busy;
  assign in_fire   = in_valid && in_ready;
  assign out_valid = busy && pace_go;
  assign out_fire  = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      tid_q <= '0;
    end else if (in_fire) begin
      src_q <= in_src;
      dst_q <= in_dst;
      tid_q <= in_tid;
    end
  end

  frag_split #(
    .LEN_W(LEN_W), .BUS_BYTES(BUS_BYTES), .MAX_BEATS(MAX_BEATS)
  ) u_split (
    .clk(clk), .rst_n(rst_n),
    .load(in_fire), .load_len(in_len), .take(out_fire),
    .busy(busy), .piece_bytes(piece_bytes), .piece_beats(piece_beats),
    .piece_last(piece_last)
  );

  frag_pace #(.CYC_CLKS(CYC_CLKS)) u_pace (
    .clk(clk), .rst_n(rst_n), .fire(out_fire), .go(pace_go)
  );

  assign out_src   = src_q;
  assign out_dst   = dst_q;
  assign out_tid   = tid_q;
  assign out_bytes = piece_bytes;
  assign out_beats = piece_beats;
  assign out_last  = piece_last;

  p_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> !in_ready);

  p_beats_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_beats) * BUS_BYTES >= 32'(out_bytes)) &&
                  (32'(out_beats) * BUS_BYTES < 32'(out_bytes) + BUS_BYTES));

  p_reopen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |=> in_ready);

  p_stay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && !out_last) |=> !in_ready);

  p_ids_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> (out_src == $past(in_src)) && (out_dst == $past(in_dst)) &&
                (out_tid == $past(in_tid)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_bytes) &&
      $stable(out_beats) && $stable(out_last) && $stable(out_tid));
endmodule

// File: tb/burst_fragmenter_bench.sv
module burst_fragmenter_bench;
  localparam int BUS = 8, BEATS = 16, LW = 16, SW = 4, DW = 4, TW = 8, CYC = 5;
  localparam int MAXF = BUS * BEATS;
  localparam int FW = $clog2(MAXF + 1);
  localparam int BW = $clog2(BEATS + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [SW-1:0] in_src = '0;
  logic [DW-1:0] in_dst = '0;
  logic [TW-1:0] in_tid = '0;
  logic [LW-1:0] in_len = '0;
  logic in_ready, out_valid, out_last;
  logic [SW-1:0] out_src;
  logic [DW-1:0] out_dst;
  logic [TW-1:0] out_tid;
  logic [FW-1:0] out_bytes;
  logic [BW-1:0] out_beats;

  always #10ns clk = ~clk;

  burst_fragmenter #(.BUS_BYTES(BUS), .MAX_BEATS(BEATS), .LEN_W(LW), .SRC_W(SW),
    .DST_W(DW), .TID_W(TW), .CYC_CLKS(CYC)) u_burst_fragmenter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_dst(in_dst), .in_tid(in_tid), .in_len(in_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_src(out_src),
    .out_dst(out_dst), .out_tid(out_tid), .out_bytes(out_bytes),
    .out_beats(out_beats), .out_last(out_last));

  int total = 0, bad = 0, cyc = 0, last_fire = -1000;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_piece(input int rem);
    return (rem > MAXF) ? MAXF : rem;
  endfunction
  function automatic int exp_beats(input int b);
    return b / BUS + (((b % BUS) != 0) ? 1 : 0);
  endfunction

  task automatic run_txn(input int s, input int d, input int t, input int len, input int rdy_pct);
    int rem, rem0, nfrag, guard, prev_bytes;
    bit fin, prev_stall;
    rem = (len < 4) ? 4 : len;
    rem0 = rem; nfrag = 0; guard = 0; fin = 0; prev_stall = 0; prev_bytes = 0;
    @(negedge clk);
    in_valid = 1'b1; in_src = SW'(s); in_dst = DW'(d); in_tid = TW'(t); in_len = LW'(len);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    chk(in_ready == 1'b0, "R2", "in_ready after accept", in_ready, 0);
    in_src = ~SW'(s); in_dst = ~DW'(d); in_tid = ~TW'(t); in_len = LW'(7); // ignored while busy
    while (!fin) begin
      bit rdy;
      rdy = ($urandom % 100) < rdy_pct;
      if (prev_stall)
        chk(out_valid && (int'(out_bytes) == prev_bytes), "R9", "held fragment bytes",
            out_bytes, prev_bytes);
      if (out_valid) begin
        int eb;
        eb = exp_piece(rem);
        chk(out_src == SW'(s) && out_dst == DW'(d), "R6", "src/dst", {out_src, out_dst},
            {SW'(s), DW'(d)});
        chk(out_tid == TW'(t), "R6", "tid", out_tid, t);
        chk(int'(out_bytes) == eb, "R3", "fragment bytes", out_bytes, eb);
        chk(int'(out_beats) == exp_beats(eb), "R4", "fragment beats", out_beats, exp_beats(eb));
        chk(out_last == (eb == rem), "R5", "last flag", out_last, eb == rem);
        chk(!in_ready, "R2", "in_ready while busy", in_ready, 0);
        if (rdy) begin
          chk(cyc + 1 - last_fire >= CYC, "R8", "handoff spacing", cyc + 1 - last_fire, CYC);
          last_fire = cyc + 1;
          rem -= eb; nfrag++;
          if (rem <= 0) begin fin = 1; in_valid = 1'b0; end
        end
        prev_stall = !rdy; prev_bytes = int'(out_bytes);
      end else begin
        chk(!prev_stall, "R9", "valid dropped before handoff", 0, 1);
        prev_stall = 0;
      end
      out_ready = rdy;
      @(negedge clk);
      guard++;
      if (guard > 20000) begin
        chk(0, "R2", "transaction never completed", guard, 0);
        fin = 1; in_valid = 1'b0;
      end
    end
    out_ready = 1'b0;
    chk(in_ready == 1'b1, "R5", "in_ready after final fragment", in_ready, 1);
    chk(nfrag == (rem0 + MAXF - 1) / MAXF, "R3", "fragment count", nfrag,
        (rem0 + MAXF - 1) / MAXF);
  endtask

  initial begin
    #4000000ns;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", "state in reset", {in_ready, out_valid}, 2);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", "idle after reset", {in_ready, out_valid}, 2);
    run_txn(1, 2, 3, 4, 100);      // R7 minimum legal
    run_txn(2, 3, 4, 1, 100);      // R7 raised to 4
    run_txn(3, 4, 5, 0, 100);      // R7 zero length
    run_txn(4, 5, 6, MAXF, 100);   // R5 exactly one full fragment
    run_txn(5, 6, 7, MAXF + 1, 100);
    run_txn(6, 7, 8, 300, 50);
    run_txn(7, 8, 9, 1000, 100);   // R8 back-to-back pacing
    run_txn(8, 9, 10, 65535, 100);
    for (int i = 0; i < 60; i++)
      run_txn(int'($urandom % 16), int'($urandom % 16), int'($urandom % 256),
              int'($urandom % 1200), 30 + int'($urandom % 71));
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule